// File: doc/BRIEF.md
# Frame-Addressed Dual Port Controller

This block sits behind a bus frame receiver and turns decoded frames into actions on two bidirectional pin groups, called port A and port B, plus a command byte. The receiver hands over an identifier strobe with the addressing bits of the identifier, then a stream of data bytes, each with a valid strobe, then an end-of-frame pulse. The block checks that the frame is meant for this device. It decides whether the frame is acknowledged, and it applies writes. For read frames it sends reply bytes in the same frame.

The lowest three identifier bits form a local address. The next `ADDR_W` bits are compared with the wired device address pins, so several devices can share one bus. Written bytes go into a shadow store and reach the port registers only at end of frame, and only if the byte count is legal for that local address. A malformed frame therefore never leaves a port partly updated. Each pin is driven from its DATA bit when its DDR bit is 1. Reads report the level seen at the pin, whatever its direction.

Top module: `fpc_port_ctrl`

## Requirements
- R1: Identifier bits [2:0] form the local address, and bit 0 set means read. The map is: 0 command write, 1 status read, 2 port A write, 3 port A read, 4 ports A+B write, 5 ports A+B read, 6 port B write, 7 port B read.
- R2: The frame is handled only when identifier bits [ADDR_W+2:3] equal `ext_addr_i`. Any other frame gives no acknowledge and no reply, and changes no output.
- R3: An accepted frame raises `ack_o` for exactly one cycle, in the cycle after `eof_i`.
- R4: The legal data byte counts are: 1 to 3 for a single-port write, exactly 6 for an A+B write, exactly 1 for a command write, and 0 for any read. With any other count, `ack_o` stays low and no register changes.
- R5: An accepted single-port write with one byte loads DATA from that byte and sets every DDR bit of that port to 1.
- R6: An accepted single-port write with two or three bytes loads DATA from byte 0 and DDR from byte 1. A DDR bit of 1 makes `pad_x_oe` high and drives the DATA bit on `pad_x_o`; a DDR bit of 0 makes the pin an input. A third byte (OPT) is accepted but has no effect, whatever its value.
- R7: An accepted A+B write takes its bytes in this order: DATA_A, DDR_A, OPT_A, DATA_B, DDR_B, OPT_B. Both OPT bytes have no effect.
- R8: The port registers and `cmd_o` change only on the clock edge at which `eof_i` is high. They never change during a frame.
- R9: A port read that addresses this device returns the `pad_x_i` level, sampled when the identifier is taken, as one byte on `rd_data_o`. `rd_valid_o` is high in the cycle after `id_valid_i`. This holds for input and output pins alike.
- R10: An A+B read returns two bytes on consecutive cycles: the port A level first, then the port B level.
- R11: An accepted command write copies its byte to `cmd_o`. A status read returns `status_i` as a single reply byte.
- R12: After reset, all DATA bits, DDR bits, `pad_x_oe`, `cmd_o`, `ack_o` and `rd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr_i | input | ADDR_W | Wired device address |
| id_valid_i | input | 1 | Identifier valid, starts a frame |
| id_i | input | ADDR_W+3 | Addressing bits of the identifier |
| byte_valid_i | input | 1 | Data byte valid |
| byte_i | input | DW | Received data byte |
| eof_i | input | 1 | End-of-frame pulse |
| status_i | input | DW | Status byte to report |
| ack_o | output | 1 | Frame accepted, one-cycle pulse |
| rd_valid_o | output | 1 | Reply byte valid |
| rd_data_o | output | DW | Reply byte |
| cmd_o | output | DW | Command register |
| pad_a_i | input | DW | Port A pin levels |
| pad_a_o | output | DW | Port A output values |
| pad_a_oe | output | DW | Port A output enables |
| pad_b_i | input | DW | Port B pin levels |
| pad_b_o | output | DW | Port B output values |
| pad_b_oe | output | DW | Port B output enables |

## Verification
The bench builds the block with its defaults: `DW` = 8 and `ADDR_W` = 3, with the device address tied to 5. The 3-bit address lets the bench send frames to the seven other device addresses and check that each is ignored. The 8-bit byte and pin width lets DDR patterns mix inputs and outputs inside one port, so a read shows both the driven value and the external level. The byte count limit of 6 lets random counts from 0 to 7 cover the legal counts and the illegal ones on both sides of each range for every local address.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int LOC_W     = 3;
   localparam int MAX_BYTES = 6;
   localparam int CNT_W     = $clog2(MAX_BYTES + 2);
   localparam int SLOTS     = 4;
   localparam int NPORT     = 2;

   typedef enum logic [LOC_W-1:0] {
      LA_CMD_WR  = 3'd0,
      LA_STAT_RD = 3'd1,
      LA_A_WR    = 3'd2,
      LA_A_RD    = 3'd3,
      LA_AB_WR   = 3'd4,
      LA_AB_RD   = 3'd5,
      LA_B_WR    = 3'd6,
      LA_B_RD    = 3'd7
   } loc_addr_e;

   // legal data byte count per local address
   function automatic logic frame_legal(input loc_addr_e la, input logic [CNT_W-1:0] n);
      logic ok;
      case (la)
         LA_CMD_WR:        ok = (n == CNT_W'(1));
         LA_AB_WR:         ok = (n == CNT_W'(6));
         LA_A_WR, LA_B_WR: ok = (n >= CNT_W'(1)) && (n <= CNT_W'(3));
         default:          ok = (n == '0);
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/fpc_frame_track.sv
module fpc_frame_track
   import fpc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      id_valid_i,
   input  logic                      match_i,
   input  loc_addr_e                 la_i,
   input  logic                      byte_valid_i,
   input  logic [DW-1:0]             byte_i,
   input  logic                      eof_i,
   output loc_addr_e                 la_o,
   output logic [CNT_W-1:0]          cnt_o,
   output logic [SLOTS-1:0][DW-1:0]  shadow_o,
   output logic                      commit_o,
   output logic                      ack_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   logic                     active_q;
   loc_addr_e                la_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [SLOTS-1:0][DW-1:0] sh_q;
   logic                     ack_q;

   assign commit_o = eof_i && active_q && frame_legal(la_q, cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         la_q     <= LA_CMD_WR;
         cnt_q    <= '0;
         sh_q     <= '0;
         ack_q    <= 1'b0;
      end else begin
         ack_q <= commit_o;
         if (id_valid_i) begin
            active_q <= match_i;
            la_q     <= la_i;
            cnt_q    <= '0;
         end else if (eof_i) begin
            active_q <= 1'b0;
         end else if (byte_valid_i && active_q) begin
            // OPT positions (2 and 5) are counted but not stored
            case (cnt_q)
               CNT_W'(0): sh_q[0] <= byte_i;
               CNT_W'(1): sh_q[1] <= byte_i;
               CNT_W'(3): sh_q[2] <= byte_i;
               CNT_W'(4): sh_q[3] <= byte_i;
               default: ;
            endcase
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign la_o     = la_q;
   assign cnt_o    = cnt_q;
   assign shadow_o = sh_q;
   assign ack_o    = ack_q;
endmodule

// File: rtl/fpc_port_reg.sv
module fpc_port_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic [DW-1:0] ddr_i,
   output logic [DW-1:0] data_o,
   output logic [DW-1:0] ddr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         ddr_o  <= '0;
      end else if (load_i) begin
         data_o <= data_i;
         ddr_o  <= ddr_i;
      end
   end
endmodule

// File: rtl/fpc_read_reply.sv
module fpc_read_reply
   import fpc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  loc_addr_e     la_i,
   input  logic [DW-1:0] pad_a_i,
   input  logic [DW-1:0] pad_b_i,
   input  logic [DW-1:0] status_i,
   output logic          rd_valid_o,
   output logic [DW-1:0] rd_data_o
);
   logic          second_q;
   logic [DW-1:0] b_hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
         second_q   <= 1'b0;
         b_hold_q   <= '0;
      end else if (start_i) begin
         rd_valid_o <= 1'b1;
         second_q   <= (la_i == LA_AB_RD);
         b_hold_q   <= pad_b_i;
         case (la_i)
            LA_STAT_RD: rd_data_o <= status_i;
            LA_B_RD:    rd_data_o <= pad_b_i;
            default:    rd_data_o <= pad_a_i;
         endcase
      end else if (second_q) begin
         rd_valid_o <= 1'b1;
         rd_data_o  <= b_hold_q;
         second_q   <= 1'b0;
      end else begin
         rd_valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/fpc_port_ctrl.sv
module fpc_port_ctrl
   import fpc_pkg::*;
#(
   parameter int DW     = 8,
   parameter int ADDR_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       ext_addr_i,
   input  logic                    id_valid_i,
   input  logic [ADDR_W+LOC_W-1:0] id_i,
   input  logic                    byte_valid_i,
   input  logic [DW-1:0]           byte_i,
   input  logic                    eof_i,
   input  logic [DW-1:0]           status_i,
   output logic                    ack_o,
   output logic                    rd_valid_o,
   output logic [DW-1:0]           rd_data_o,
   output logic [DW-1:0]           cmd_o,
   input  logic [DW-1:0]           pad_a_i,
   output logic [DW-1:0]           pad_a_o,
   output logic [DW-1:0]           pad_a_oe,
   input  logic [DW-1:0]           pad_b_i,
   output logic [DW-1:0]           pad_b_o,
   output logic [DW-1:0]           pad_b_oe
);
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("fpc_port_ctrl: DW must lie in 1..32");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("fpc_port_ctrl: ADDR_W must lie in 1..8");
   end

   logic                     match;
   loc_addr_e                la_in, la_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [SLOTS-1:0][DW-1:0] sh;
   logic                     commit;
   logic [NPORT-1:0]         load;
   logic [NPORT-1:0][DW-1:0] data_in, ddr_in, data_q, ddr_q;
   logic [DW-1:0]            cmd_q;

   assign match = (id_i[ADDR_W+LOC_W-1:LOC_W] == ext_addr_i);
   assign la_in = loc_addr_e'(id_i[LOC_W-1:0]);

   fpc_frame_track #(.DW(DW)) u_track (
      .clk, .rst_n,
      .id_valid_i, .match_i(match), .la_i(la_in),
      .byte_valid_i, .byte_i, .eof_i,
      .la_o(la_q), .cnt_o(cnt_q), .shadow_o(sh),
      .commit_o(commit), .ack_o
   );

   fpc_read_reply #(.DW(DW)) u_reply (
      .clk, .rst_n,
      .start_i(id_valid_i && match && la_in[0]),
      .la_i(la_in), .pad_a_i, .pad_b_i, .status_i,
      .rd_valid_o, .rd_data_o
   );

   // route shadow bytes to the port that the local address selects
   always_comb begin
      load = '0;
      for (int p = 0; p < NPORT; p++) begin
         data_in[p] = sh[0];
         ddr_in[p]  = (cnt_q == CNT_W'(1)) ? {DW{1'b1}} : sh[1];
      end
      if (commit) begin
         case (la_q)
            LA_A_WR: load[0] = 1'b1;
            LA_B_WR: load[1] = 1'b1;
            LA_AB_WR: begin
               load       = '1;
               data_in[1] = sh[2];
               ddr_in[1]  = sh[3];
            end
            default: ;
         endcase
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      fpc_port_reg #(.DW(DW)) u_reg (
         .clk, .rst_n,
         .load_i(load[p]), .data_i(data_in[p]), .ddr_i(ddr_in[p]),
         .data_o(data_q[p]), .ddr_o(ddr_q[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmd_q <= '0;
      else if (commit && la_q == LA_CMD_WR) cmd_q <= sh[0];
   end

   assign cmd_o    = cmd_q;
   assign pad_a_o  = data_q[0];
   assign pad_a_oe = ddr_q[0];
   assign pad_b_o  = data_q[1];
   assign pad_b_oe = ddr_q[1];
endmodule

// File: rtl/fpc_port_ctrl_chk.sv
module fpc_port_ctrl_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          eof_i,
   input logic          id_valid_i,
   input logic          ack_o,
   input logic          rd_valid_o,
   input logic [DW-1:0] cmd_o,
   input logic [DW-1:0] pad_a_o,
   input logic [DW-1:0] pad_a_oe,
   input logic [DW-1:0] pad_b_o,
   input logic [DW-1:0] pad_b_oe
);
   AST_ACK_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(eof_i)); // R3

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o); // R3

   AST_PORTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eof_i) |-> ($stable(pad_a_o) && $stable(pad_a_oe) &&
                         $stable(pad_b_o) && $stable(pad_b_oe))); // R8

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eof_i) |-> $stable(cmd_o)); // R8

   AST_REPLY_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid_o) |-> $past(id_valid_i)); // R9
endmodule

bind fpc_port_ctrl fpc_port_ctrl_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .id_valid_i(id_valid_i),
   .ack_o(ack_o), .rd_valid_o(rd_valid_o), .cmd_o(cmd_o),
   .pad_a_o(pad_a_o), .pad_a_oe(pad_a_oe), .pad_b_o(pad_b_o), .pad_b_oe(pad_b_oe)
);

// File: tb/fpc_port_ctrl_bench.sv
module fpc_port_ctrl_bench;
   localparam int DW = 8;
   localparam int AW = 3;
   localparam logic [AW-1:0] MY_ADDR = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0]   ext_addr = MY_ADDR;
   logic            id_valid = 1'b0;
   logic [AW+2:0]   id = '0;
   logic            byte_valid = 1'b0;
   logic [DW-1:0]   byte_d = '0;
   logic            eof = 1'b0;
   logic [DW-1:0]   status = 8'h3C;
   logic            ack, rd_valid;
   logic [DW-1:0]   rd_data, cmd;
   logic [DW-1:0]   pa_i, pa_o, pa_oe, pb_i, pb_o, pb_oe;
   logic [DW-1:0]   drv_a = 8'h00, drv_b = 8'h00;

   assign pa_i = (pa_oe & pa_o) | (~pa_oe & drv_a);
   assign pb_i = (pb_oe & pb_o) | (~pb_oe & drv_b);

   fpc_port_ctrl #(.DW(DW), .ADDR_W(AW)) u_fpc_port_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_addr_i(ext_addr), .id_valid_i(id_valid),
      .id_i(id), .byte_valid_i(byte_valid), .byte_i(byte_d), .eof_i(eof),
      .status_i(status), .ack_o(ack), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
      .cmd_o(cmd), .pad_a_i(pa_i), .pad_a_o(pa_o), .pad_a_oe(pa_oe),
      .pad_b_i(pb_i), .pad_b_o(pb_o), .pad_b_oe(pb_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   logic [DW-1:0] m_da = '0, m_ra = '0, m_db = '0, m_rb = '0, m_cmd = '0;
   logic [DW-1:0] bb [8];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit legal(input logic [2:0] la, input int n);
      if (la[0])        return n == 0;
      if (la == 3'd0)   return n == 1;
      if (la == 3'd4)   return n == 6;
      return n >= 1 && n <= 3;
   endfunction

   function automatic logic [DW-1:0] lvl(input logic [DW-1:0] d, input logic [DW-1:0] r,
                                         input logic [DW-1:0] x);
      return (r & d) | (~r & x);
   endfunction

   task automatic check_ports(input string req);
      check({req, " pad_a_oe"}, 32'(pa_oe), 32'(m_ra));
      check({req, " pad_a_o"},  32'(pa_o & m_ra), 32'(m_da & m_ra));
      check({req, " pad_b_oe"}, 32'(pb_oe), 32'(m_rb));
      check({req, " pad_b_o"},  32'(pb_o & m_rb), 32'(m_db & m_rb));
      check({req, " cmd_o"},    32'(cmd), 32'(m_cmd));
   endtask

   // one frame; bb[0..n-1] hold the data bytes
   task automatic frame(input logic [2:0] la, input bit hit, input int n, input string req);
      logic [AW-1:0] a;
      bit ok;
      a = hit ? MY_ADDR : (MY_ADDR ^ AW'(1 + $urandom % 7));
      ok = hit && legal(la, n);
      @(negedge clk);
      id_valid = 1'b1;
      id = {a, la};
      @(negedge clk);
      id_valid = 1'b0;
      // R9 R10 R11 R2: reply in the cycle after the identifier
      check({req, " rd_valid"}, 32'(rd_valid), 32'(hit && la[0]));
      if (hit && la[0]) begin
         case (la)
            3'd1:    check({req, " status R11"}, 32'(rd_data), 32'(status));
            3'd7:    check({req, " port B read R9"}, 32'(rd_data), 32'(lvl(m_db, m_rb, drv_b)));
            default: check({req, " port A read R9"}, 32'(rd_data), 32'(lvl(m_da, m_ra, drv_a)));
         endcase
         if (la == 3'd5) begin
            @(negedge clk);
            check({req, " second byte R10"}, 32'(rd_valid), 32'd1);
            check({req, " B after A R10"}, 32'(rd_data), 32'(lvl(m_db, m_rb, drv_b)));
         end
      end
      for (int i = 0; i < n; i++) begin
         byte_valid = 1'b1;
         byte_d = bb[i];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      check_ports({req, " mid-frame R8"});
      eof = 1'b1;
      @(negedge clk);
      eof = 1'b0;
      check({req, " ack R3 R4"}, 32'(ack), 32'(ok));
      if (ok) begin
         case (la)
            3'd0: m_cmd = bb[0];
            3'd2: begin m_da = bb[0]; m_ra = (n == 1) ? 8'hFF : bb[1]; end
            3'd6: begin m_db = bb[0]; m_rb = (n == 1) ? 8'hFF : bb[1]; end
            3'd4: begin m_da = bb[0]; m_ra = bb[1]; m_db = bb[3]; m_rb = bb[4]; end
            default: ;
         endcase
      end
      check_ports({req, " after eof"});
      @(negedge clk);
      check({req, " ack pulse R3"}, 32'(ack), 32'd0);
   endtask

   task automatic set_bytes(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                            input logic [DW-1:0] b2, input logic [DW-1:0] b3,
                            input logic [DW-1:0] b4, input logic [DW-1:0] b5);
      bb[0] = b0; bb[1] = b1; bb[2] = b2; bb[3] = b3; bb[4] = b4; bb[5] = b5;
      bb[6] = 8'hEE; bb[7] = 8'hDD;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      check("R12 oe_a", 32'(pa_oe), 32'd0);
      check("R12 oe_b", 32'(pb_oe), 32'd0);
      check("R12 cmd", 32'(cmd), 32'd0);
      check("R12 ack", 32'(ack), 32'd0);
      check("R12 rd_valid", 32'(rd_valid), 32'd0);

      drv_a = 8'h5A; drv_b = 8'hC3;
      set_bytes(8'hA5, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00);
      frame(3'd2, 1, 1, "R5 single byte A");
      set_bytes(8'h96, 8'h0F, 8'h7E, 8'h00, 8'h00, 8'h00);
      frame(3'd2, 1, 3, "R6 three bytes OPT nonzero");
      frame(3'd3, 1, 0, "R9 mixed direction read");
      set_bytes(8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
      frame(3'd2, 1, 4, "R4 four bytes rejected");
      frame(3'd2, 1, 0, "R4 zero bytes rejected");
      set_bytes(8'h12, 8'hF0, 8'h01, 8'h34, 8'h3C, 8'h80);
      frame(3'd4, 1, 6, "R7 A+B write");
      frame(3'd4, 1, 5, "R4 A+B five bytes");
      frame(3'd5, 1, 0, "R10 A+B read");
      set_bytes(8'h77, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
      frame(3'd6, 1, 2, "R6 two byte B");
      frame(3'd7, 1, 0, "R1 B read");
      frame(3'd0, 1, 1, "R11 cmd write");
      set_bytes(8'h99, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
      frame(3'd0, 1, 2, "R4 cmd two bytes");
      frame(3'd1, 1, 0, "R11 status read");
      frame(3'd3, 1, 1, "R4 read with data");
      frame(3'd2, 0, 1, "R2 foreign address write");
      frame(3'd5, 0, 0, "R2 foreign address read");

      for (int k = 0; k < 400; k++) begin
         logic [2:0] la;
         bit hit;
         int n;
         drv_a = 8'($urandom); drv_b = 8'($urandom);
         status = 8'($urandom);
         la = 3'($urandom);
         hit = ($urandom % 4) != 0;
         n = (la[0] && ($urandom % 2)) ? 0 : int'($urandom % 8);
         set_bytes(8'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom), 8'($urandom));
         bb[6] = 8'($urandom); bb[7] = 8'($urandom);
         frame(la, hit, n, "R1 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule